// File: doc/BRIEF.md
# PHY Interrupt Status and Mask Unit

This block keeps the interrupt state of an Ethernet PHY's management register space. It holds two 16-bit registers that a management serial slave reaches through a plain register access port. The mask register sits at address 25 and the status register at address 26. A link monitor sends single-cycle event pulses for eight causes. An event whose mask bit is set latches a status bit. A read of the status register returns every latched bit and clears them all. A summary bit in the status word feeds an active-low interrupt pin, and the pin has its own enable.

Some causes are gated by state that lives in other management registers. The speed-change and duplex-change causes latch only while auto-negotiation is enabled. The downshift cause latches only while all four advertised-ability bits are set. Both conditions come into the block as plain level inputs.

The access port takes one access per cycle and has no back-pressure. A strobe is always accepted in the cycle it is high. Read data is combinational from the current register state, and the clear-on-read takes effect at the clock edge that ends the read cycle.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset the status word is 0x0000, the mask register is 0x0000 and `irq_n` is high.
- R2: A write to address 25 stores `wdata & 0xFE06`. Mask bits 15, 14:9, 2 and 1 are read/write. Bits 8:3 and bit 0 always read 0. A read of address 25 returns the stored mask.
- R3: `link_evt` bit k maps to status bit P(k): k=0 speed→14, 1 link→13, 2 duplex→12, 3 auto-neg error→11, 4 auto-neg complete→10, 5 powered-device detect→9, 6 downshift→2, 7 master/slave error→1. A pulse on bit k latches P(k) at the next edge only if mask bit P(k) is 1. With the mask bit 0 the pulse leaves the status word unchanged.
- R4: Status bits 14 and 12 latch only while `autoneg_en` is 1.
- R5: Status bit 2 latches only while `adv_abil` is 4'b1111.
- R6: Status bit 15 reads 1 exactly when any of status bits 14:1 is 1. Bits 8:3 and 0 read 0.
- R7: A read of address 26 returns the current status word. After that cycle's clock edge, every bit that was returned is 0.
- R8: An event that latches in the same cycle as a status read is still set after the read-clear.
- R9: Writes to address 26 do not change the status word.
- R10: `irq_n` is low exactly when mask bit 15 and status bit 15 are both 1. With mask bit 15 at 0 the pin stays high and status bits still latch.
- R11: A read of any address other than 25 or 26 returns 0x0000 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe, one access per cycle |
| acc_rd | input | 1 | Read strobe, one access per cycle |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the addressed register (combinational) |
| link_evt | input | 8 | Event pulses from the link monitor, one bit per cause |
| autoneg_en | input | 1 | Auto-negotiation enable level, gates causes 14 and 12 |
| adv_abil | input | 4 | Advertised-ability bits, all set enables cause 2 |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
Two functions can land in the same cycle: the clear-on-read of the status register and the latching of a new event. The bench provokes this by pulsing an event in the very cycle it issues a status read. It judges the read data against a model of the state before the edge, and it expects a second read to show only the new event. It also sweeps every cause against every mask, auto-negotiation and ability setting, and checks the pin against the model on every cycle.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 5;
  localparam int N_EVT     = 8;
  localparam int ABIL_W    = 4;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 5'd25;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd26;
  localparam int SUM_BIT   = 15;
  localparam logic [REG_W-1:0] MASK_RW   = 16'hFE06;
  localparam logic [REG_W-1:0] CAUSE_SET = 16'h7E06;

  typedef enum logic [2:0] {
    EV_SPEED  = 3'd0,
    EV_LINK   = 3'd1,
    EV_DUPLEX = 3'd2,
    EV_AN_ERR = 3'd3,
    EV_AN_OK  = 3'd4,
    EV_PD_DET = 3'd5,
    EV_DSHIFT = 3'd6,
    EV_MS_ERR = 3'd7
  } evt_e;

  function automatic int cause_pos(input int k);
    case (k)
      0: cause_pos = 14;
      1: cause_pos = 13;
      2: cause_pos = 12;
      3: cause_pos = 11;
      4: cause_pos = 10;
      5: cause_pos = 9;
      6: cause_pos = 2;
      default: cause_pos = 1;
    endcase
  endfunction
endpackage

// File: rtl/phy_irq_mask_reg.sv
module phy_irq_mask_reg
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wdata & MASK_RW;
  end
endmodule

// File: rtl/phy_irq_cause_gate.sv
module phy_irq_cause_gate
  import phy_irq_pkg::*;
(
  input  logic [N_EVT-1:0]  evt,
  input  logic [REG_W-1:0]  mask_q,
  input  logic              an_en,
  input  logic [ABIL_W-1:0] abil,
  output logic [REG_W-1:0]  set_vec
);
  logic [N_EVT-1:0] qual;

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_qual
      if (gi == int'(EV_SPEED) || gi == int'(EV_DUPLEX)) begin : g_an
        assign qual[gi] = an_en;
      end else if (gi == int'(EV_DSHIFT)) begin : g_ds
        assign qual[gi] = &abil;
      end else begin : g_free
        assign qual[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_EVT; k++) begin
      set_vec[cause_pos(k)] = evt[k] & qual[k] & mask_q[cause_pos(k)];
    end
  end
endmodule

// File: rtl/phy_irq_status_reg.sv
module phy_irq_status_reg
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] stat_word
);
  logic [REG_W-1:0] kept;
  logic             summary;

  assign kept    = rd_clr ? '0 : status_q;
  assign summary = |status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (kept | set_vec) & CAUSE_SET;
  end

  always_comb begin
    stat_word          = status_q;
    stat_word[SUM_BIT] = summary;
  end
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic [REG_W-1:0]  acc_rdata,
  input  logic [N_EVT-1:0]  link_evt,
  input  logic              autoneg_en,
  input  logic [ABIL_W-1:0] adv_abil,
  output logic              irq_n
);
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] stat_word;
  logic             mask_wr;
  logic             stat_rd;

  assign mask_wr = acc_wr && (acc_addr == ADDR_MASK);
  assign stat_rd = acc_rd && (acc_addr == ADDR_STAT);

  phy_irq_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (acc_wdata),
    .mask_q (mask_q)
  );

  phy_irq_cause_gate u_gate (
    .evt     (link_evt),
    .mask_q  (mask_q),
    .an_en   (autoneg_en),
    .abil    (adv_abil),
    .set_vec (set_vec)
  );

  phy_irq_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_clr    (stat_rd),
    .set_vec   (set_vec),
    .status_q  (status_q),
    .stat_word (stat_word)
  );

  always_comb begin
    case (acc_addr)
      ADDR_MASK: acc_rdata = mask_q;
      ADDR_STAT: acc_rdata = stat_word;
      default:   acc_rdata = '0;
    endcase
  end

  assign irq_n = ~(mask_q[SUM_BIT] & stat_word[SUM_BIT]);
endmodule

// File: rtl/phy_irq_checker.sv
module phy_irq_checker
  import phy_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              autoneg_en,
  input logic [ABIL_W-1:0] adv_abil,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  set_vec,
  input logic [REG_W-1:0]  status_q,
  input logic              irq_n
);
  logic stat_rd;
  assign stat_rd = acc_rd && (acc_addr == ADDR_STAT);

  // R7, R8: after a status read only bits latched in that cycle remain
  a_r8_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((status_q & ~$past(set_vec)) == '0));

  // R3: a masked cause never turns on
  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

  // R4: speed and duplex causes stay off without auto-negotiation
  a_r4_an_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoneg_en && !status_q[14] && !status_q[12]) |=> (!status_q[14] && !status_q[12]));

  // R5: downshift cause stays off unless all ability bits are set
  a_r5_abil_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&adv_abil) && !status_q[2]) |=> !status_q[2]);

  // R9: status writes leave the status word alone
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !stat_rd && set_vec == '0) |=> $stable(status_q));

  // R10: pin stays released while its enable is off
  a_r10_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[SUM_BIT] |-> irq_n);

  // R10: pin asserted implies something is pending
  a_r10_pin_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (status_q != '0));
endmodule

bind phy_irq_unit phy_irq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_wr     (acc_wr),
  .acc_rd     (acc_rd),
  .acc_addr   (acc_addr),
  .autoneg_en (autoneg_en),
  .adv_abil   (adv_abil),
  .mask_q     (mask_q),
  .set_vec    (set_vec),
  .status_q   (status_q),
  .irq_n      (irq_n)
);

// File: tb/phy_irq_unit_bench.sv
module phy_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_rd = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic [7:0]  link_evt = '0;
  logic        autoneg_en = 1'b0;
  logic [3:0]  adv_abil = '0;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_mask = '0;
  logic [15:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_unit u_phy_irq_unit (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .link_evt(link_evt), .autoneg_en(autoneg_en), .adv_abil(adv_abil),
    .irq_n(irq_n)
  );

  function automatic int bpos(input int k);
    int t[8] = '{14, 13, 12, 11, 10, 9, 2, 1};
    return t[k];
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] s);
    return s | ((s != 0) ? 16'h8000 : 16'h0000);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive at negedge, sample mid-cycle, update model at the edge.
  task automatic step(input logic wr, input logic rd, input logic [4:0] addr,
                      input logic [15:0] wd, input logic [7:0] evt, input string tag);
    logic [15:0] sets;
    logic [15:0] exp_rd;
    @(negedge clk);
    acc_wr = wr; acc_rd = rd; acc_addr = addr; acc_wdata = wd; link_evt = evt;
    #(CLK_PERIOD/4);
    if (rd) begin
      exp_rd = (addr == 5'd25) ? m_mask : (addr == 5'd26) ? exp_word(m_stat) : 16'h0000;
      check(tag, acc_rdata, exp_rd);
    end
    check("R10", {15'd0, irq_n}, {15'd0, !(m_mask[15] && m_stat != 0)});
    sets = '0;
    for (int k = 0; k < 8; k++) begin
      if (evt[k] && m_mask[bpos(k)] &&
          (((k == 0 || k == 2) ? autoneg_en : 1'b1)) &&
          ((k == 6) ? (adv_abil == 4'hF) : 1'b1))
        sets[bpos(k)] = 1'b1;
    end
    @(posedge clk);
    m_stat = ((rd && addr == 5'd26) ? 16'h0 : m_stat) | sets;
    if (wr && addr == 5'd25) m_mask = wd & 16'hFE06;
    #1;
    acc_wr = 0; acc_rd = 0; link_evt = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    step(0, 1, 5'd26, 0, 0, "R1");
    step(0, 1, 5'd25, 0, 0, "R1");
    // R2 mask write/readback, reserved bits read zero
    step(1, 0, 5'd25, 16'hFFFF, 0, "R2");
    step(0, 1, 5'd25, 0, 0, "R2");
    step(1, 0, 5'd25, 16'h01F9, 0, "R2");
    step(0, 1, 5'd25, 0, 0, "R2");
    // R3 R4 R5 R6 R7 sweep over every cause and configuration
    for (int m = 0; m < 2; m++)
      for (int an = 0; an < 2; an++)
        for (int ab = 0; ab < 2; ab++)
          for (int k = 0; k < 8; k++) begin
            autoneg_en = an[0];
            adv_abil = ab[0] ? 4'hF : 4'h7;
            step(1, 0, 5'd25, m[0] ? 16'hFFFF : 16'h8000, 0, "R2");
            step(0, 0, 5'd0, 0, 8'd1 << k, "R3");
            step(0, 1, 5'd26, 0, 0, (k == 0 || k == 2) ? "R4" : (k == 6) ? "R5" : "R6");
            step(0, 1, 5'd26, 0, 0, "R7");
          end
    autoneg_en = 1; adv_abil = 4'hF;
    step(1, 0, 5'd25, 16'hFFFF, 0, "R2");
    // R6 several causes at once
    step(0, 0, 5'd0, 0, 8'hA5, "R6");
    step(0, 1, 5'd26, 0, 0, "R6");
    // R8 event in the same cycle as the read
    step(0, 0, 5'd0, 0, 8'h02, "R8");
    step(0, 1, 5'd26, 0, 8'h40, "R8");
    step(0, 1, 5'd26, 0, 0, "R8");
    step(0, 1, 5'd26, 0, 0, "R8");
    // R9 status write ignored
    step(0, 0, 5'd0, 0, 8'h08, "R9");
    step(1, 0, 5'd26, 16'h0000, 0, "R9");
    step(1, 0, 5'd26, 16'hFFFF, 0, "R9");
    step(0, 1, 5'd26, 0, 0, "R9");
    // R10 pin disabled, status still records
    step(1, 0, 5'd25, 16'h7FFF, 0, "R10");
    step(0, 0, 5'd0, 0, 8'h10, "R10");
    step(0, 0, 5'd0, 0, 0, "R10");
    step(0, 1, 5'd26, 0, 0, "R10");
    // R11 other addresses read zero and leave state intact
    step(0, 0, 5'd0, 0, 8'h01, "R11");
    step(0, 1, 5'd3, 0, 0, "R11");
    step(0, 1, 5'd24, 0, 0, "R11");
    step(0, 1, 5'd26, 0, 0, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule